// File: doc/BRIEF.md
# Dual-Reader Ring Pointer Tracker

This block keeps the bookkeeping for a circular buffer held in external memory that is filled by one producer and drained by two independent consumers. It holds a shared write pointer and one read pointer per consumer, all counted in 64-bit words between a programmable base address and base plus size. Each pointer carries a wrap flag that marks a return to the start of the buffer. For each consumer the block derives how many words are still waiting.

Strobes from the memory-side logic move the pointers. The block itself refuses moves that would read an empty region or overwrite words that a consumer has not yet taken. A host sees every value through a byte-wide read port. Values wider than a byte are split into low, middle and high bytes. Reading the low byte freezes the upper bytes, so the host can assemble a value that is consistent even while the pointers keep moving.

Top module: `ring_ptr_tracker`

## Requirements
- R1: While `rst` is high at a clock edge, every pointer is loaded with `base_addr`, every wrap flag is cleared, both item counts become zero, the frozen upper bytes are cleared and `host_rdata` is 0.
- R2: Each accepted advance moves its pointer up by exactly one word. An advance taken from `base_addr + buf_size - 1` returns the pointer to `base_addr`. A pointer never leaves the range from `base_addr` to `base_addr + buf_size - 1`.
- R3: A pointer's wrap flag is bit 19 of its 20-bit field, which is bit 3 of that field's high byte. It sets when the pointer returns to base. It clears after the host reads the low byte of that pointer's field. If a return to base occurs in the same cycle as that read, the flag stays set.
- R4: Each consumer's item count is (write pointer − its read pointer) modulo `buf_size`, in words. It is presented as a 20-bit field whose bit 19 is 0, and it is always less than `buf_size`.
- R5: An advance strobe for a consumer whose item count is zero has no effect.
- R6: The write strobe has no effect while either consumer's count equals `buf_size - 1`.
- R7: `host_addr[4:2]` selects the field: 0 is the write pointer, 1 is the pointer of consumer A, 2 is the pointer of consumer B, 3 is the count of A and 4 is the count of B. `host_addr[1:0]` selects the byte: 0 is low, 1 is middle and 2 is high. Any other field or byte reads as 0. The byte appears on `host_rdata` in the cycle after `host_rd` is sampled and is held until the next read.
- R8: A low-byte read returns the live low byte. A middle or high byte read returns the byte captured at the most recent low-byte read of the same field, whatever the pointers have done since.
- R9: The two consumers are independent. Moves of one consumer's pointer leave the other consumer's pointer and count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_addr | input | 19 | First word address of the buffer |
| buf_size | input | 19 | Buffer length in 64-bit words (at least 2) |
| wr_adv | input | 1 | Producer wrote one word |
| rda_adv | input | 1 | Consumer A took one word |
| rdb_adv | input | 1 | Consumer B took one word |
| host_rd | input | 1 | Host byte read strobe |
| host_addr | input | 5 | Field select in [4:2], byte select in [1:0] |
| host_rdata | output | 8 | Byte returned one cycle after the read |

## Verification
The bench aims at the edge where a pointer leaves the last word and lands on base. A design that is off by one there would run past the buffer or skip its first word. It drives a wrap in the same cycle as the host read that clears the flag, where an ordering mistake loses the wrap. It drives the buffer to exactly one word short of full and then issues more writes, which a loose full test would let overwrite consumer B's data. Advances into an empty buffer test that a read pointer cannot overtake the writer. Upper bytes are read after the pointers have moved on, which exposes any upper byte that follows the live value instead of the frozen copy.

// File: rtl/rbp_pkg.sv
package rbp_pkg;

    localparam int ADDR_W_DFLT = 19;
    localparam int NUM_PTRS    = 3;
    localparam int NUM_FIELDS  = 5;
    localparam int FSEL_W      = 3;
    localparam int BSEL_W      = 2;

    typedef enum logic [FSEL_W-1:0] {
        FLD_WPTR = 3'd0,
        FLD_APTR = 3'd1,
        FLD_BPTR = 3'd2,
        FLD_ACNT = 3'd3,
        FLD_BCNT = 3'd4
    } field_e;

    typedef enum int {
        PIDX_WR = 0,
        PIDX_A  = 1,
        PIDX_B  = 2
    } ptr_idx_e;

    typedef struct packed {
        logic wr;
        logic rd_a;
        logic rd_b;
    } adv_t;

    function automatic int bytes_for(input int bits);
        return (bits + 7) / 8;
    endfunction

endpackage

// File: rtl/rbp_pointer.sv
module rbp_pointer #(
    parameter int AW = rbp_pkg::ADDR_W_DFLT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] size,
    input  logic          adv,
    input  logic          clr,
    output logic [AW-1:0] ptr,
    output logic          wrap
);

    logic [AW-1:0] last_addr;
    logic          at_last;
    logic          wrap_evt;

    assign last_addr = base + size - AW'(1);
    assign at_last   = (ptr == last_addr);
    assign wrap_evt  = adv && at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr  <= base;
            wrap <= 1'b0;
        end else begin
            if (adv) begin
                ptr <= at_last ? base : ptr + AW'(1);
            end
            if (wrap_evt) begin
                wrap <= 1'b1;
            end else if (clr) begin
                wrap <= 1'b0;
            end
        end
    end

    AST_WRAP_TO_BASE: assert property (@(posedge clk) disable iff (rst)
        (adv && at_last) |=> (wrap && ptr == base)); // R3
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (adv && !at_last) |=> (ptr == $past(ptr) + AW'(1))); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(ptr)); // R2
    AST_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (ptr - base) < size); // R2

endmodule

// File: rtl/rbp_level.sv
module rbp_level #(
    parameter int AW = rbp_pkg::ADDR_W_DFLT
) (
    input  logic [AW-1:0] wr_ptr,
    input  logic [AW-1:0] rd_ptr,
    input  logic [AW-1:0] size,
    output logic [AW-1:0] count
);

    logic [AW-1:0] raw;

    assign raw = wr_ptr - rd_ptr;

    always_comb begin
        if (wr_ptr >= rd_ptr) begin
            count = raw;
        end else begin
            count = raw + size;
        end
    end

endmodule

// File: rtl/rbp_hostregs.sv
module rbp_hostregs #(
    parameter int AW  = rbp_pkg::ADDR_W_DFLT,
    parameter int NF  = rbp_pkg::NUM_FIELDS,
    parameter int FSW = rbp_pkg::FSEL_W,
    parameter int BSW = rbp_pkg::BSEL_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rd_en,
    input  logic [FSW+BSW-1:0]       addr,
    input  logic [NF-1:0][AW:0]      fields,
    output logic [7:0]               rdata,
    output logic [NF-1:0]            low_hit
);

    localparam int FW = AW + 1;
    localparam int NB = rbp_pkg::bytes_for(FW);
    localparam int PW = NB * 8;

    logic [FSW-1:0]         fsel;
    logic [BSW-1:0]         bsel;
    logic [NF-1:0][PW-1:0]  live;
    logic [NF-1:0][PW-1:0]  snap;
    logic [7:0]             sel_byte;
    logic                   addr_ok;

    assign fsel    = addr[FSW+BSW-1:BSW];
    assign bsel    = addr[BSW-1:0];
    assign addr_ok = (int'(fsel) < NF) && (int'(bsel) < NB);

    for (genvar f = 0; f < NF; f++) begin : g_field
        assign live[f]    = PW'(fields[f]);
        assign low_hit[f] = rd_en && (fsel == FSW'(f)) && (bsel == '0);

        always_ff @(posedge clk) begin
            if (rst) begin
                snap[f] <= '0;
            end else if (low_hit[f]) begin
                snap[f] <= live[f];
            end
        end
    end

    always_comb begin
        sel_byte = 8'h00;
        if (addr_ok) begin
            if (bsel == '0) begin
                sel_byte = live[fsel][7:0];
            end else begin
                sel_byte = snap[fsel][int'(bsel)*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= 8'h00;
        end else if (rd_en) begin
            rdata <= sel_byte;
        end
    end

    AST_BAD_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !addr_ok) |=> (rdata == 8'h00)); // R7
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata)); // R7
    AST_UPPER_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (low_hit == '0) |=> $stable(snap)); // R8

endmodule

// File: rtl/ring_ptr_tracker.sv
module ring_ptr_tracker #(
    parameter int AW  = rbp_pkg::ADDR_W_DFLT,
    parameter int FSW = rbp_pkg::FSEL_W,
    parameter int BSW = rbp_pkg::BSEL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [AW-1:0]      base_addr,
    input  logic [AW-1:0]      buf_size,
    input  logic               wr_adv,
    input  logic               rda_adv,
    input  logic               rdb_adv,
    input  logic               host_rd,
    input  logic [FSW+BSW-1:0] host_addr,
    output logic [7:0]         host_rdata
);
    import rbp_pkg::*;

    localparam int NP = NUM_PTRS;
    localparam int NF = NUM_FIELDS;

    logic [NP-1:0][AW-1:0] ptr;
    logic [NP-1:0]         wrap;
    logic [NP-1:0]         step;
    logic [NF-1:0]         low_hit;
    logic [NF-1:0][AW:0]   fields;
    logic [AW-1:0]         cnt_a;
    logic [AW-1:0]         cnt_b;
    logic [AW-1:0]         full_lvl;
    logic                  full;
    adv_t                  req;
    adv_t                  ok;

    assign req      = '{wr: wr_adv, rd_a: rda_adv, rd_b: rdb_adv};
    assign full_lvl = buf_size - AW'(1);
    assign full     = (cnt_a == full_lvl) || (cnt_b == full_lvl);

    always_comb begin
        ok.wr   = req.wr   && !full;
        ok.rd_a = req.rd_a && (cnt_a != '0);
        ok.rd_b = req.rd_b && (cnt_b != '0);
    end

    assign step[PIDX_WR] = ok.wr;
    assign step[PIDX_A]  = ok.rd_a;
    assign step[PIDX_B]  = ok.rd_b;

    for (genvar p = 0; p < NP; p++) begin : g_ptr
        rbp_pointer #(.AW(AW)) u_ptr (
            .clk  (clk),
            .rst  (rst),
            .base (base_addr),
            .size (buf_size),
            .adv  (step[p]),
            .clr  (low_hit[p]),
            .ptr  (ptr[p]),
            .wrap (wrap[p])
        );
        assign fields[p] = {wrap[p], ptr[p]};
    end

    rbp_level #(.AW(AW)) u_lvl_a (
        .wr_ptr (ptr[PIDX_WR]),
        .rd_ptr (ptr[PIDX_A]),
        .size   (buf_size),
        .count  (cnt_a)
    );

    rbp_level #(.AW(AW)) u_lvl_b (
        .wr_ptr (ptr[PIDX_WR]),
        .rd_ptr (ptr[PIDX_B]),
        .size   (buf_size),
        .count  (cnt_b)
    );

    assign fields[FLD_ACNT] = {1'b0, cnt_a};
    assign fields[FLD_BCNT] = {1'b0, cnt_b};

    rbp_hostregs #(.AW(AW), .NF(NF), .FSW(FSW), .BSW(BSW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (host_rd),
        .addr    (host_addr),
        .fields  (fields),
        .rdata   (host_rdata),
        .low_hit (low_hit)
    );

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (cnt_a < buf_size) && (cnt_b < buf_size)); // R4
    AST_EMPTY_A_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rda_adv && cnt_a == '0) |=> $stable(ptr[PIDX_A])); // R5
    AST_EMPTY_B_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rdb_adv && cnt_b == '0) |=> $stable(ptr[PIDX_B])); // R5
    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        (wr_adv && full) |=> $stable(ptr[PIDX_WR])); // R6
    AST_A_INDEP_OF_B: assert property (@(posedge clk) disable iff (rst)
        (!rda_adv && !wr_adv) |=> $stable(cnt_a)); // R9

endmodule

// File: tb/ring_ptr_tracker_test.sv
module ring_ptr_tracker_test;

    localparam int AW = 19;
    localparam logic [AW-1:0] BASE = 19'h012FC;
    localparam logic [AW-1:0] SIZE = 19'd8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_adv = 1'b0, rda_adv = 1'b0, rdb_adv = 1'b0;
    logic          host_rd = 1'b0;
    logic [4:0]    host_addr = '0;
    logic [7:0]    host_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t sb[$];

    logic [AW-1:0] mp[3];
    logic          mw[3];
    logic [23:0]   msnap[5];

    always #5 clk = ~clk;

    ring_ptr_tracker uut (
        .clk(clk), .rst(rst), .base_addr(BASE), .buf_size(SIZE),
        .wr_adv(wr_adv), .rda_adv(rda_adv), .rdb_adv(rdb_adv),
        .host_rd(host_rd), .host_addr(host_addr), .host_rdata(host_rdata)
    );

    function automatic logic [AW-1:0] mcnt(input int r);
        if (mp[0] >= mp[r]) return mp[0] - mp[r];
        return mp[0] + SIZE - mp[r];
    endfunction

    function automatic logic [23:0] mfield(input int f);
        if (f < 3) return {4'b0, mw[f], mp[f]};
        return {5'b0, mcnt(f - 2)};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 3; i++) begin mp[i] = BASE; mw[i] = 1'b0; end
        for (int i = 0; i < 5; i++) msnap[i] = '0;
    endtask

    // One cycle of stimulus; updates the model and queues any expected read byte.
    task automatic cyc(input bit w, input bit a, input bit b, input bit rd,
                       input logic [4:0] addr, input string tag);
        int fs, bs;
        bit acc[3];
        logic [7:0] e;
        @(negedge clk);
        wr_adv = w; rda_adv = a; rdb_adv = b; host_rd = rd; host_addr = addr;
        fs = int'(addr[4:2]);
        bs = int'(addr[1:0]);
        if (rd) begin
            logic [23:0] lv;
            e = 8'h00;
            if (fs < 5 && bs < 3) begin
                lv = mfield(fs);
                e = (bs == 0) ? lv[7:0] : msnap[fs][bs*8 +: 8];
            end
            sb.push_back('{val: e, tag: tag});
            if (fs < 5 && bs == 0) msnap[fs] = mfield(fs);
        end
        acc[0] = w && (mcnt(1) != SIZE - 1) && (mcnt(2) != SIZE - 1);
        acc[1] = a && (mcnt(1) != 0);
        acc[2] = b && (mcnt(2) != 0);
        for (int i = 0; i < 3; i++) begin
            if (rd && fs == i && bs == 0) mw[i] = 1'b0;
            if (acc[i]) begin
                if (mp[i] == BASE + SIZE - 1) begin
                    mp[i] = BASE;
                    mw[i] = 1'b1;
                end else begin
                    mp[i] = mp[i] + 1;
                end
            end
        end
    endtask

    task automatic rd(input int f, input int by, input string tag);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, {3'(f), 2'(by)}, tag);
    endtask

    // Monitor: pops the scoreboard one cycle after each sampled read.
    always @(posedge clk) begin
        if (!rst && host_rd) begin
            exp_t it;
            #1;
            if (sb.size() == 0) begin
                check(1'b0, "R7 unexpected read", host_rdata, 8'h00);
            end else begin
                it = sb.pop_front();
                check(host_rdata == it.val, it.tag, host_rdata, it.val);
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        check(host_rdata == 8'h00, "R1 rdata in reset", host_rdata, 8'h00);
        rst = 1'b0;

        // R1: all fields hold reset values
        for (int f = 0; f < 5; f++) rd(f, 0, "R1 low byte after reset");
        rd(0, 1, "R8 mid of write ptr");
        rd(0, 2, "R8 high of write ptr");

        // R2: writes step the pointer
        repeat (3) cyc(1, 0, 0, 0, '0, "");
        rd(3, 0, "R4 count A after three writes");
        rd(0, 0, "R2 write ptr low");

        // R5: consumer A drains, then tries once more on empty
        repeat (4) cyc(0, 1, 0, 0, '0, "");
        rd(3, 0, "R5 count A empty");
        rd(1, 0, "R5 A ptr not past writer");
        rd(4, 0, "R9 count B untouched by A");

        // R6: fill until B is one short of full, extra writes refused
        repeat (10) cyc(1, 0, 0, 0, '0, "");
        rd(4, 0, "R6 count B at size-1");
        rd(0, 0, "R6 write ptr stops");
        rd(0, 1, "R8 write ptr mid after capture");

        // R3: write wraps to base
        repeat (4) cyc(0, 0, 1, 0, '0, "");
        cyc(1, 0, 0, 0, '0, "");
        rd(0, 0, "R3 write ptr at base after wrap");
        rd(0, 2, "R3 wrap flag visible in high byte");
        rd(0, 0, "R3 low read again");
        rd(0, 2, "R3 wrap flag cleared by read");

        // R3: wrap of A in the same cycle as its low-byte read
        for (int k = 0; k < 40; k++) begin
            if (mp[1] == BASE + SIZE - 1 && mcnt(1) != 0) break;
            cyc(1, 1, 1, 0, '0, "");
        end
        cyc(0, 1, 0, 1, 5'b00100, "R3 A ptr low at wrap cycle");
        rd(1, 2, "R3 flag kept when wrap meets read");

        // R8: frozen upper bytes do not follow later moves
        rd(2, 0, "R8 B ptr low capture");
        repeat (3) cyc(1, 0, 1, 0, '0, "");
        rd(2, 1, "R8 B ptr mid frozen");
        rd(2, 2, "R8 B ptr high frozen");

        // R7: unmapped field and byte
        rd(5, 0, "R7 unmapped field");
        rd(0, 3, "R7 unmapped byte");

        // R4: mixed pattern
        begin
            logic [7:0] lf = 8'hA5;
            for (int k = 0; k < 80; k++) begin
                lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
                cyc(lf[0], lf[1], lf[2], lf[3], {lf[6:4] % 3'd5, 2'b00}, "R4 mixed traffic");
            end
        end
        rd(3, 0, "R4 count A final");
        rd(4, 0, "R4 count B final");

        cyc(0, 0, 0, 0, '0, "");
        repeat (3) @(negedge clk);
        if (sb.size() != 0) check(1'b0, "R7 reads missing", 8'(sb.size()), 8'h00);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule